// File: doc/BRIEF.md
# Tail-Biting Rate-2/3 Convolutional Encoder

This block encodes a 16-bit message with a four-state, nonsystematic convolutional code. The two outputs use generators 7 and 5 (octal). The code is tail-biting: before the first bit is encoded, the two-bit shift register is loaded with the final two bits of the message. The encoder therefore ends in the same state it started in, and no termination bits are sent. The 32 mother-code bits are then punctured down to 24, which gives an overall rate of 2/3.

A message is taken in through a valid/ready handshake. The encoded bits come out serially, one per cycle, with a valid flag. The whole 24-bit codeword is also presented in parallel, with a one-cycle strobe, once the last serial bit has gone out. A new message can be accepted in the same cycle as that strobe, so consecutive blocks run back to back with no gap. A check flag reports when the closing state differs from the preloaded state. On a correct encoder this flag never rises.

Top module: `tbpc_encoder`

## Requirements
- R1: After reset, msgReady is 1, and codeValid, wordValid and stateErr are all 0.
- R2: msgReady is 0 from the cycle after a message is accepted until the cycle in which wordValid rises. While msgReady is 0, msgValid and msgData have no effect on the code produced.
- R3: The serial output is valid for exactly 24 consecutive cycles, starting in the cycle right after the accepting clock edge.
- R4: At acceptance the encoder memory is preloaded from the message. The newest memory bit s1 takes msgData[0], and the older memory bit s2 takes msgData[1]. Message bits are then encoded from msgData[15] down to msgData[0].
- R5: For each message bit u, the coded output X equals u^s1^s2 and the coded output Y equals u^s2. The memory then shifts: s2 takes s1, and s1 takes u.
- R6: Message bits are punctured in pairs. For the first bit of each pair, X and then Y are sent. For the second bit, only Y is sent. The serial order is therefore X1, Y1, Y2 for each pair.
- R7: wordValid is a single-cycle pulse in the cycle after the last serial bit. In that cycle codeWord holds the 24 serial bits, with the first bit sent at bit 23 and the last at bit 0.
- R8: stateErr stays 0 for every message, because the closing state always equals the preloaded state.
- R9: In the cycle where wordValid is 1, msgReady is also 1. A message presented in that cycle is accepted without an idle cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| msgValid | input | 1 | Message present |
| msgData | input | 16 | Message; bit 15 is encoded first |
| msgReady | output | 1 | Encoder idle, so a message can be accepted |
| codeValid | output | 1 | codeBit carries a code bit |
| codeBit | output | 1 | Serial punctured code bit |
| wordValid | output | 1 | One-cycle strobe: codeWord is complete |
| codeWord | output | 24 | Parallel punctured codeword, first bit at the MSB |
| stateErr | output | 1 | Closing state differs from the preloaded state |

## Verification
Take the edge where msgValid and msgReady are both high as edge 0. Serial bit k is then due in the cycle after edge k, for k from 0 to 23. wordValid and codeWord are due in the cycle after edge 24, and msgReady returns in that same cycle. The bench drives its inputs and samples the outputs on the falling edge. It steps once per cycle from the acceptance, so each bit is compared in exactly the cycle it is due. The next message is offered in that same cycle, which exercises the back-to-back case.

// File: rtl/tbpc_pkg.sv
package tbpc_pkg;
  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic load;     // capture message, preload memory
    logic emit;     // a code bit is presented this cycle
    logic xSel;     // emitted bit is X (else Y)
    logic advance;  // consume current message bit after this cycle
    logic last;     // final code bit of the block
  } strobe_t;
endpackage

// File: rtl/tbpc_ctrl.sv
module tbpc_ctrl
  import tbpc_pkg::*;
#(
  parameter int MSG_BITS = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    msgValid,
  output logic    msgReady,
  output strobe_t stb
);
  localparam int PAIRS  = MSG_BITS / 2;
  localparam int PAIR_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  logic              busy;
  logic [1:0]        phase;
  logic [PAIR_W-1:0] pairCnt;
  logic              lastPair;

  assign msgReady = !busy;
  assign lastPair = (pairCnt == PAIR_W'(PAIRS - 1));

  always_comb begin
    stb         = '0;
    stb.load    = msgValid && !busy;
    stb.emit    = busy;
    stb.xSel    = busy && (phase == 2'd0);
    stb.advance = busy && (phase != 2'd0);
    stb.last    = busy && (phase == 2'd2) && lastPair;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      phase   <= 2'd0;
      pairCnt <= '0;
    end else if (stb.load) begin
      busy    <= 1'b1;
      phase   <= 2'd0;
      pairCnt <= '0;
    end else if (busy) begin
      if (phase == 2'd2) begin
        phase <= 2'd0;
        if (lastPair) busy <= 1'b0;
        else          pairCnt <= pairCnt + 1'b1;
      end else begin
        phase <= phase + 2'd1;
      end
    end
  end

  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && msgReady) |=> (stb.emit && stb.xSel)); // R6
  AST_LAST_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    stb.last |=> msgReady); // R9
  AST_BUSY_NOLOAD: assert property (@(posedge clk) disable iff (!rstN)
    (stb.emit && !stb.last) |=> !msgReady); // R2
endmodule

// File: rtl/tbpc_datapath.sv
module tbpc_datapath
  import tbpc_pkg::*;
#(
  parameter int MSG_BITS  = 16,
  parameter int CODE_BITS = MSG_BITS * 3 / 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [MSG_BITS-1:0]  msgData,
  output logic                 codeBit,
  output logic                 wordValid,
  output logic [CODE_BITS-1:0] codeWord,
  output logic                 stateErr
);
  logic [MSG_BITS-1:0]  msgReg;
  logic [CODE_BITS-1:0] wordAcc;
  logic s1, s2;          // newest and older memory bits
  logic initS1, initS2;  // preloaded state, kept for the closing check
  logic curBit;

  assign curBit   = msgReg[MSG_BITS-1];
  assign codeBit  = stb.xSel ? (curBit ^ s1 ^ s2) : (curBit ^ s2);
  assign codeWord = wordAcc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgReg <= '0;
      s1     <= 1'b0;
      s2     <= 1'b0;
      initS1 <= 1'b0;
      initS2 <= 1'b0;
    end else if (stb.load) begin
      msgReg <= msgData;
      s1     <= msgData[0];
      s2     <= msgData[1];
      initS1 <= msgData[0];
      initS2 <= msgData[1];
    end else if (stb.advance) begin
      msgReg <= msgReg << 1;
      s1     <= curBit;
      s2     <= s1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordAcc   <= '0;
      wordValid <= 1'b0;
      stateErr  <= 1'b0;
    end else begin
      if (stb.emit) wordAcc <= {wordAcc[CODE_BITS-2:0], codeBit};
      wordValid <= stb.last;
      stateErr  <= stb.last && ({curBit, s1} != {initS1, initS2});
    end
  end

  AST_LOAD_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.load) |-> (s1 == $past(msgData[0]) && s2 == $past(msgData[1]))); // R4
  AST_WORD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid); // R7
  AST_TAIL_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    !stateErr); // R8
endmodule

// File: rtl/tbpc_encoder.sv
module tbpc_encoder
  import tbpc_pkg::*;
#(
  parameter int MSG_BITS = 16,
  localparam int CODE_BITS = MSG_BITS * 3 / 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 msgValid,
  input  logic [MSG_BITS-1:0]  msgData,
  output logic                 msgReady,
  output logic                 codeValid,
  output logic                 codeBit,
  output logic                 wordValid,
  output logic [CODE_BITS-1:0] codeWord,
  output logic                 stateErr
);
  strobe_t stb;

  tbpc_ctrl #(.MSG_BITS(MSG_BITS)) ctrl (
    .clk(clk), .rstN(rstN), .msgValid(msgValid),
    .msgReady(msgReady), .stb(stb)
  );

  tbpc_datapath #(.MSG_BITS(MSG_BITS), .CODE_BITS(CODE_BITS)) dp (
    .clk(clk), .rstN(rstN), .stb(stb), .msgData(msgData),
    .codeBit(codeBit), .wordValid(wordValid),
    .codeWord(codeWord), .stateErr(stateErr)
  );

  assign codeValid = stb.emit;
endmodule

// File: tb/tbpc_encoder_test.sv
module tbpc_encoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        msgValid = 1'b0;
  logic [15:0] msgData = '0;
  logic        msgReady, codeValid, codeBit, wordValid, stateErr;
  logic [23:0] codeWord;
  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  tbpc_encoder uut (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgData(msgData),
    .msgReady(msgReady), .codeValid(codeValid), .codeBit(codeBit),
    .wordValid(wordValid), .codeWord(codeWord), .stateErr(stateErr)
  );

  // reference model built from R4, R5, R6
  function automatic logic [23:0] refCode(input logic [15:0] m);
    logic [23:0] o;
    logic a, b, u;
    int idx;
    o = '0; a = m[0]; b = m[1]; idx = 23;
    for (int i = 15; i >= 0; i--) begin
      u = m[i];
      if (((15 - i) % 2) == 0) begin o[idx] = u ^ a ^ b; idx--; end
      o[idx] = u ^ b; idx--;
      b = a; a = u;
    end
    return o;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // starts and ends at a falling edge where msgReady is expected high
  task automatic runBlock(input logic [15:0] m);
    logic [23:0] e;
    e = refCode(m);
    check(msgReady == 1'b1, "R9", "ready before accept", 32'(msgReady), 1);
    msgData = m; msgValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    msgData = ~m;            // offered while busy, must be ignored (R2)
    for (int k = 0; k < 24; k++) begin
      check(codeValid && codeBit == e[23-k] && !msgReady, "R3 R5 R6 R2",
            $sformatf("bit %0d of %04h", k, m),
            {29'(0), msgReady, codeValid, codeBit}, {30'(0), 1'b1, e[23-k]});
      @(negedge clk);
    end
    check(wordValid && codeWord == e && !codeValid, "R7",
          $sformatf("word of %04h", m), {7'(0), wordValid, codeWord},
          {8'h01, e});
    check(!stateErr, "R8", "state flag", 32'(stateErr), 0);
    msgValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(msgReady && !codeValid && !wordValid && !stateErr, "R1", "reset state",
          {28'(0), msgReady, codeValid, wordValid, stateErr}, 32'h8);
    // corner messages, R4 preload cases
    runBlock(16'h0000);
    runBlock(16'hFFFF);
    runBlock(16'h8000);
    runBlock(16'h0001);
    runBlock(16'h0002);
    runBlock(16'h0003);
    runBlock(16'hAAAA);
    runBlock(16'h5555);
    // idle gap: nothing emitted, strobe gone (R3, R7)
    @(negedge clk);
    check(!codeValid && !wordValid && msgReady, "R3", "idle quiet",
          {29'(0), codeValid, wordValid, msgReady}, 1);
    // walking ones, then a spread sweep, all back to back
    for (int i = 0; i < 16; i++) runBlock(16'(1) << i);
    for (int i = 0; i < 3000; i++) runBlock(16'(i * 40503 + 17));
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule